// File: doc/BRIEF.md
# Baud Tick Generator

This block produces the bit-rate timing for a serial port. The port can run asynchronously or synchronously. An 8-bit divisor X sets the length of a free-running timer, which counts X+1 clock cycles per lap. A fixed prescaler follows the timer and divides its laps again. The prescaler ratio depends on the mode:

- 64 in asynchronous slow mode.
- 16 in asynchronous fast mode.
- 4 in synchronous mode. The fast-select bit has no effect here.

The output is a one-cycle pulse, once every N = ratio × (X+1) clock cycles. As an example, a 16 MHz clock with X = 25 in asynchronous slow mode gives N = 1664, which is about 9615 bit/s.

A divisor write restarts the timer and the prescaler at once, so a new rate applies without waiting for the old period to end. A change of the effective prescale ratio also restarts both stages. So does the enable input going high. While enable is low, both stages are held at zero.

Top module: `baud_tick_gen`

## Requirements
- R1: With `sync_mode`=0 and `high_speed`=0, consecutive `tick` pulses are 64×(X+1) clock cycles apart, for every X from 0 to 255.
- R2: With `sync_mode`=0 and `high_speed`=1, consecutive `tick` pulses are 16×(X+1) clock cycles apart.
- R3: With `sync_mode`=1, consecutive `tick` pulses are 4×(X+1) clock cycles apart. Changing `high_speed` in this mode neither restarts the count nor moves the pulse phase.
- R4: A clock edge with `div_we`=1 loads `div_wdata` as X and clears both the timer and the prescaler. The first `tick` after that edge goes high exactly N edges later, where N uses the new X. The output is low in the cycle right after the write.
- R5: Reset (synchronous, active high) sets X to 0 and clears both stages, with `tick` low. The first `tick` rises N edges after the last edge with reset high.
- R6: An edge at which the effective prescale ratio has changed (asynchronous slow / asynchronous fast / synchronous) clears both stages. The first `tick` comes N edges later, where N uses the new ratio.
- R7: While `en`=0, no `tick` is produced and both stages are held at zero. After `en` rises, the first `tick` comes N edges after the first edge at which `en` is high.
- R8: `tick` is never high for two cycles in a row. It is a registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the timer and the prescaler at zero |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | New divisor value X |
| sync_mode | input | 1 | 1 = synchronous mode (ratio 4), 0 = asynchronous |
| high_speed | input | 1 | In asynchronous mode: 1 = ratio 16, 0 = ratio 64 |
| tick | output | 1 | One-cycle bit-rate pulse |

## Verification
Some rules are checked on every cycle:

- `tick` is one cycle wide.
- `tick` stays quiet after a write and while the block is disabled.
- The divisor loads and resets correctly.
- The distance between two ticks equals ratio × (X+1), using the ratio and X currently held. A cycle counter restarts on every clear.

Other behaviour only the bench scenarios can show. These are:

- The absolute tick spacings at the extreme divisors 0 and 255, in every mode.
- The exact delay to the first tick after a mid-period write, after a mode change and after enable rises.
- That toggling the fast bit in synchronous mode keeps the running phase.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int unsigned PS_CNT_W = 6;

    typedef enum logic [1:0] {
        PS_ASYNC_SLOW = 2'd0,
        PS_ASYNC_FAST = 2'd1,
        PS_SYNC       = 2'd2
    } ps_sel_e;

    typedef struct packed {
        ps_sel_e sel;
        logic    clear;
        logic    run;
    } brg_ctl_t;

    function automatic ps_sel_e pick_sel(input logic sync_m, input logic fast);
        if (sync_m) begin
            return PS_SYNC;
        end
        if (fast) begin
            return PS_ASYNC_FAST;
        end
        return PS_ASYNC_SLOW;
    endfunction

    // terminal value of the prescaler (ratio minus one)
    function automatic logic [PS_CNT_W-1:0] ps_last(input ps_sel_e s);
        case (s)
            PS_SYNC:       return PS_CNT_W'(3);
            PS_ASYNC_FAST: return PS_CNT_W'(15);
            default:       return PS_CNT_W'(63);
        endcase
    endfunction

    function automatic int unsigned ps_ratio(input ps_sel_e s);
        return int'(ps_last(s)) + 1;
    endfunction

endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
    import brg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             high_speed,
    output logic [DIV_W-1:0] div_q,
    output ps_sel_e          sel_q,
    output brg_ctl_t         ctl
);

    ps_sel_e sel_now;
    logic    en_q;
    logic    restart;

    assign sel_now = pick_sel(sync_mode, high_speed);

    // restart on a divisor write, on a change of the effective ratio
    // (the fast bit alone does not change it in synchronous mode), or on enable rising
    assign restart = div_we | (sel_now != sel_q) | (en & ~en_q);

    always_comb begin
        ctl.sel   = sel_now;
        ctl.run   = en;
        ctl.clear = restart | ~en;
    end

    always_ff @(posedge clk) begin
        sel_q <= sel_now;
        en_q  <= en;
        if (rst) begin
            div_q <= '0;
        end else if (div_we) begin
            div_q <= div_wdata;
        end
    end

endmodule

// File: rtl/brg_timer.sv
module brg_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             step
);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == limit);
    assign step   = run & ~clear & at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            if (at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale
    import brg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    step,
    input  ps_sel_e sel,
    output logic    tick
);

    logic [PS_CNT_W-1:0] pcnt;
    logic                last;

    assign last = (pcnt == ps_last(sel));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt <= '0;
            tick <= 1'b0;
        end else begin
            tick <= step & last;
            if (step) begin
                if (last) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + PS_CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import brg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             high_speed,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    ps_sel_e          sel_q;
    brg_ctl_t         ctl;
    logic             clear;
    logic             step;

    assign clear = ctl.clear;

    brg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .div_we     (div_we),
        .div_wdata  (div_wdata),
        .sync_mode  (sync_mode),
        .high_speed (high_speed),
        .div_q      (div_q),
        .sel_q      (sel_q),
        .ctl        (ctl)
    );

    brg_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .run   (ctl.run),
        .limit (div_q),
        .step  (step)
    );

    brg_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .step  (step),
        .sel   (ctl.sel),
        .tick  (tick)
    );

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk
    import brg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             div_we,
    input logic [DIV_W-1:0] div_wdata,
    input logic             tick,
    input logic [DIV_W-1:0] div_q,
    input ps_sel_e          sel_q,
    input logic             clear
);

    localparam int GAP_W = DIV_W + PS_CNT_W + 2;

    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] want;

    assign want = GAP_W'(ps_ratio(sel_q)) * (GAP_W'(div_q) + GAP_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap <= '0;
        end else if (tick) begin
            gap <= GAP_W'(1);
        end else begin
            gap <= gap + GAP_W'(1);
        end
    end

    // R1, R2, R3: spacing equals ratio x (X+1)
    a_r1_period: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap == want);

    a_r8_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r4_write_quiet: assert property (@(posedge clk) disable iff (rst)
        div_we |=> !tick);

    a_r4_div_load: assert property (@(posedge clk) disable iff (rst)
        div_we |=> div_q == $past(div_wdata));

    a_r5_div_reset: assert property (@(posedge clk)
        rst |=> (div_q == '0 && !tick));

    a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick);

endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .tick      (tick),
    .div_q     (div_q),
    .sel_q     (sel_q),
    .clear     (clear)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       sync_mode = 1'b1;
    logic       high_speed = 1'b0;
    logic       tick;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    baud_tick_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .div_we     (div_we),
        .div_wdata  (div_wdata),
        .sync_mode  (sync_mode),
        .high_speed (high_speed),
        .tick       (tick)
    );

    // {sync, fast, X, expected spacing}
    localparam logic [33:0] VEC [12] = '{
        {1'b0, 1'b0, 8'd25,  24'd1664},
        {1'b0, 1'b1, 8'd25,  24'd416},
        {1'b1, 1'b0, 8'd25,  24'd104},
        {1'b1, 1'b1, 8'd25,  24'd104},
        {1'b1, 1'b0, 8'd0,   24'd4},
        {1'b0, 1'b0, 8'd0,   24'd64},
        {1'b0, 1'b1, 8'd0,   24'd16},
        {1'b0, 1'b0, 8'd255, 24'd16384},
        {1'b0, 1'b1, 8'd255, 24'd4096},
        {1'b1, 1'b1, 8'd255, 24'd1024},
        {1'b0, 1'b1, 8'd3,   24'd64},
        {1'b1, 1'b0, 8'd7,   24'd32}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // count edges from the current negedge until tick is seen high
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!tick && n < 70000);
    endtask

    // write divisor and mode; returns at the negedge after the write edge
    task automatic load(input logic s, input logic f, input logic [7:0] x);
        @(negedge clk);
        sync_mode  = s;
        high_speed = f;
        div_wdata  = x;
        div_we     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        div_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int cnt;
        string req;

        // R5: reset state and default divisor (sync mode held across reset)
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tick == 1'b0, "R5 tick low in reset", int'(tick), 0);
        rst = 1'b0;
        wait_tick(n);
        chk(n == 4, "R5 first tick with X=0 after reset", n, 4);

        // table walk: R1/R2/R3 spacing, R4 first tick after write, R8 width
        foreach (VEC[i]) begin
            int exp_n;
            exp_n = int'(VEC[i][23:0]);
            req = VEC[i][33] ? "R3" : (VEC[i][32] ? "R2" : "R1");
            load(VEC[i][33], VEC[i][32], VEC[i][31:24]);
            wait_tick(n);
            chk(n == exp_n, "R4 first tick after write", n, exp_n);
            @(posedge clk);
            @(negedge clk);
            chk(tick == 1'b0, "R8 tick one cycle wide", int'(tick), 0);
            n = 1;
            if (!tick) begin
                wait_tick(cnt);
                n = cnt + 1;
            end
            chk(n == exp_n, req, n, exp_n);
        end

        // R4: write in the middle of a long period
        load(1'b0, 1'b1, 8'd100);
        repeat (500) @(negedge clk);
        chk(tick == 1'b0, "R4 no tick before period ends", int'(tick), 0);
        load(1'b1, 1'b0, 8'd9);
        wait_tick(n);
        chk(n == 40, "R4 mid-period write restarts", n, 40);

        // R3: fast bit toggled in synchronous mode keeps phase
        repeat (10) begin
            @(posedge clk);
            @(negedge clk);
        end
        high_speed = 1'b1;
        wait_tick(n);
        chk(n == 30, "R3 fast bit ignored in sync mode", n, 30);

        // R6: ratio change in asynchronous mode restarts
        load(1'b0, 1'b0, 8'd3);
        wait_tick(n);
        chk(n == 256, "R1 async slow X=3", n, 256);
        repeat (10) begin
            @(posedge clk);
            @(negedge clk);
        end
        high_speed = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wait_tick(n);
        chk(n == 64, "R6 ratio change restarts", n, 64);

        // R7: disable holds everything quiet
        en = 1'b0;
        cnt = 0;
        repeat (300) begin
            @(posedge clk);
            @(negedge clk);
            if (tick) cnt++;
        end
        chk(cnt == 0, "R7 no tick while disabled", cnt, 0);
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wait_tick(n);
        chk(n == 64, "R7 first tick after enable", n, 64);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule